// File: doc/BRIEF.md
# Paged Address Translation Unit

This block sits between a 16-bit CPU bus and the rest of the memory system. It turns every bus address into either a physical memory address or a device-register access. It does this by looking up a small page table. The address space is cut into 2 KiB pages. One table serves loads and another serves stores, so a page can read from one place and write somewhere else, for example read-only memory that traps writes to a bank-switch device. Each entry holds a device flag and a physical page base. For a direct page, the physical address is the base followed by the in-page offset. For a device page, the untouched CPU address is handed to the device side.

Bank-switch logic outside the block reprograms entries through a one-clock configuration port. Several entries may point at the same base, which is how the 2 KiB internal RAM appears as mirrored copies across the low 8 KiB. The bottom 512 bytes of the bus hold the zero page and the stack. These never consult a table: they always land in internal RAM. Results come out one clock after the request, from registers.

Top module: `page_xlat`

## Requirements
- R1: After reset, entries 0 to 3 of both tables are direct with base 0, and entries 4 to 31 are device entries. All outputs are 0 while and after reset until a request arrives.
- R2: A request with req_valid high produces out_valid high on the next clock, with out_write equal to the request's req_write. Back-to-back requests give back-to-back results.
- R3: When out_valid is high, exactly one of out_mem and out_dev is high. When out_valid is low, out_valid, out_write, out_mem, out_dev and out_addr are all 0.
- R4: The table index is req_addr[15:11]. For a direct entry, out_mem is 1 and out_addr is {base[8:0], req_addr[10:0]}.
- R5: For a device entry, out_dev is 1 and out_addr is req_addr zero-extended to 20 bits.
- R6: Requests with req_write=0 use the read table and requests with req_write=1 use the write table. An update to one table leaves the other unchanged.
- R7: Addresses 0x0000 to 0x01FF ignore both tables and give out_mem=1 with out_addr = {RAM_PAGE, req_addr[10:0]}, where RAM_PAGE defaults to 0. 0x0200 already uses the table.
- R8: A configuration write with cfg_we=1 updates entry cfg_idx in the table picked by cfg_sel (0 = read table, 1 = write table). cfg_dev=1 marks the entry as a device entry and cfg_base gives the base. A lookup in the same clock sees the old entry, and the next clock sees the new one.
- R9: Entries that share a base map different CPU pages to the same physical addresses. After reset, 0x0A05 and 0x1A05 both give 0x00205.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 16 | CPU bus address |
| cfg_we | input | 1 | Table entry update strobe |
| cfg_sel | input | 1 | Table to update: 0 read, 1 write |
| cfg_idx | input | 5 | Entry index to update |
| cfg_dev | input | 1 | New entry device flag |
| cfg_base | input | 9 | New entry physical page base |
| out_valid | output | 1 | Registered result valid |
| out_write | output | 1 | Direction of the translated access |
| out_mem | output | 1 | Access goes to physical memory |
| out_dev | output | 1 | Access goes to the device port |
| out_addr | output | 20 | Physical address, or zero-extended CPU address for devices |

## Verification
On every cycle, the assertions check the following: the one-clock latency and the direction echo, the one-hot split between memory and device strobes, the idle zeros, the fast path for the zero page and stack, that the in-page offset passes through, and that the raw address passes through on device accesses. Only the bench scenarios can show that the correct table and entry were used. These cover the reset contents, split read and write maps, mirrored bases, and that an update in the same clock as a lookup stays invisible until the next clock. The bench does this against its own model of both tables.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  // Which of the two maps a configuration write targets.
  typedef enum logic {
    TBL_READ  = 1'b0,
    TBL_WRITE = 1'b1
  } tbl_sel_e;
endpackage

// File: rtl/pxl_table.sv
// One page map: storage written on the clock, read combinationally.
module pxl_table #(
  parameter int ENTRIES      = 32,
  parameter int IDX_W        = 5,
  parameter int BASE_W       = 9,
  parameter int RESET_DIRECT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic              wdev,
  input  logic [BASE_W-1:0] wbase,
  input  logic [IDX_W-1:0]  ridx,
  output logic              rdev,
  output logic [BASE_W-1:0] rbase
);
  localparam int ENT_W = BASE_W + 1;

  logic [ENT_W-1:0] store [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        store[i] <= (i < RESET_DIRECT) ? {1'b0, {BASE_W{1'b0}}}
                                       : {1'b1, {BASE_W{1'b0}}};
      end
    end else if (we) begin
      store[widx] <= {wdev, wbase};
    end
  end

  assign {rdev, rbase} = store[ridx];
endmodule

// File: rtl/pxl_lookup.sv
// Turns a selected entry plus the bus address into a destination.
module pxl_lookup #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BITS  = 11,
  parameter int PHYS_W     = 20,
  parameter int FAST_LIMIT = 'h0200,
  parameter int RAM_PAGE   = 0
) (
  input  logic                          [ADDR_W-1:0] addr,
  input  logic                                       ent_dev,
  input  logic               [PHYS_W-PAGE_BITS-1:0]  ent_base,
  output logic                                       is_mem,
  output logic                                       is_dev,
  output logic                          [PHYS_W-1:0] phys
);
  localparam int BASE_W = PHYS_W - PAGE_BITS;
  localparam logic [ADDR_W-1:0] LIMIT = FAST_LIMIT[ADDR_W-1:0];
  localparam logic [BASE_W-1:0] RAM_B = RAM_PAGE[BASE_W-1:0];

  logic fast;
  assign fast = (addr < LIMIT);

  always_comb begin
    if (fast) begin
      is_mem = 1'b1;
      is_dev = 1'b0;
      phys   = {RAM_B, addr[PAGE_BITS-1:0]};
    end else if (ent_dev) begin
      is_mem = 1'b0;
      is_dev = 1'b1;
      phys   = {{(PHYS_W-ADDR_W){1'b0}}, addr};
    end else begin
      is_mem = 1'b1;
      is_dev = 1'b0;
      phys   = {ent_base, addr[PAGE_BITS-1:0]};
    end
  end
endmodule

// File: rtl/page_xlat.sv
module page_xlat #(
  parameter int ADDR_W       = 16,
  parameter int PAGE_BITS    = 11,
  parameter int PHYS_W       = 20,
  parameter int FAST_LIMIT   = 'h0200,
  parameter int RAM_PAGE     = 0,
  parameter int RESET_DIRECT = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            req_valid,
  input  logic                            req_write,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic                            cfg_we,
  input  logic                            cfg_sel,
  input  logic [ADDR_W-PAGE_BITS-1:0]     cfg_idx,
  input  logic                            cfg_dev,
  input  logic [PHYS_W-PAGE_BITS-1:0]     cfg_base,
  output logic                            out_valid,
  output logic                            out_write,
  output logic                            out_mem,
  output logic                            out_dev,
  output logic [PHYS_W-1:0]               out_addr
);
  import pxl_pkg::*;

  localparam int IDX_W   = ADDR_W - PAGE_BITS;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int BASE_W  = PHYS_W - PAGE_BITS;
  localparam int NTBL    = 2;

  logic [IDX_W-1:0]  page_idx;
  logic              t_dev  [NTBL];
  logic [BASE_W-1:0] t_base [NTBL];

  assign page_idx = req_addr[ADDR_W-1:PAGE_BITS];

  for (genvar g = 0; g < NTBL; g++) begin : g_tbl
    localparam tbl_sel_e MY_SEL = tbl_sel_e'(g);
    logic tbl_we;
    assign tbl_we = cfg_we && (tbl_sel_e'(cfg_sel) == MY_SEL);

    pxl_table #(
      .ENTRIES      (ENTRIES),
      .IDX_W        (IDX_W),
      .BASE_W       (BASE_W),
      .RESET_DIRECT (RESET_DIRECT)
    ) u_table (
      .clk   (clk),
      .rst   (rst),
      .we    (tbl_we),
      .widx  (cfg_idx),
      .wdev  (cfg_dev),
      .wbase (cfg_base),
      .ridx  (page_idx),
      .rdev  (t_dev[g]),
      .rbase (t_base[g])
    );
  end

  logic              sel_dev;
  logic [BASE_W-1:0] sel_base;
  assign sel_dev  = req_write ? t_dev[TBL_WRITE]  : t_dev[TBL_READ];
  assign sel_base = req_write ? t_base[TBL_WRITE] : t_base[TBL_READ];

  logic              nx_mem;
  logic              nx_dev;
  logic [PHYS_W-1:0] nx_addr;

  pxl_lookup #(
    .ADDR_W     (ADDR_W),
    .PAGE_BITS  (PAGE_BITS),
    .PHYS_W     (PHYS_W),
    .FAST_LIMIT (FAST_LIMIT),
    .RAM_PAGE   (RAM_PAGE)
  ) u_lookup (
    .addr     (req_addr),
    .ent_dev  (sel_dev),
    .ent_base (sel_base),
    .is_mem   (nx_mem),
    .is_dev   (nx_dev),
    .phys     (nx_addr)
  );

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      out_valid <= 1'b0;
      out_write <= 1'b0;
      out_mem   <= 1'b0;
      out_dev   <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= 1'b1;
      out_write <= req_write;
      out_mem   <= nx_mem;
      out_dev   <= nx_dev;
      out_addr  <= nx_addr;
    end
  end
endmodule

// File: rtl/page_xlat_chk.sv
module page_xlat_chk #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BITS  = 11,
  parameter int PHYS_W     = 20,
  parameter int FAST_LIMIT = 'h0200,
  parameter int RAM_PAGE   = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              out_valid,
  input logic              out_write,
  input logic              out_mem,
  input logic              out_dev,
  input logic [PHYS_W-1:0] out_addr
);
  localparam int BASE_W = PHYS_W - PAGE_BITS;
  localparam logic [ADDR_W-1:0] LIMIT = FAST_LIMIT[ADDR_W-1:0];
  localparam logic [BASE_W-1:0] RAM_B = RAM_PAGE[BASE_W-1:0];

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (out_valid && out_write == $past(req_write)));

  assert_idle_follow_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);

  assert_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_mem ^ out_dev));

  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_mem && !out_dev && !out_write && out_addr == '0));

  assert_offset_R4: assert property (@(posedge clk) disable iff (rst)
    out_mem |-> out_addr[PAGE_BITS-1:0] == $past(req_addr[PAGE_BITS-1:0]));

  assert_dev_addr_R5: assert property (@(posedge clk) disable iff (rst)
    out_dev |-> out_addr == {{(PHYS_W-ADDR_W){1'b0}}, $past(req_addr)});

  assert_fast_path_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr < LIMIT) |=>
      (out_mem && out_addr == {RAM_B, $past(req_addr[PAGE_BITS-1:0])}));
endmodule

bind page_xlat page_xlat_chk #(
  .ADDR_W     (ADDR_W),
  .PAGE_BITS  (PAGE_BITS),
  .PHYS_W     (PHYS_W),
  .FAST_LIMIT (FAST_LIMIT),
  .RAM_PAGE   (RAM_PAGE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .out_valid (out_valid),
  .out_write (out_write),
  .out_mem   (out_mem),
  .out_dev   (out_dev),
  .out_addr  (out_addr)
);

// File: tb/tb_page_xlat.sv
module tb_page_xlat;
  localparam int CLK_PERIOD = 10;
  localparam int PHYS_W = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0, cfg_dev = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic [8:0]  cfg_base = '0;
  logic        out_valid, out_write, out_mem, out_dev;
  logic [19:0] out_addr;

  int n_run = 0;
  int n_fail = 0;

  page_xlat dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_dev(cfg_dev), .cfg_base(cfg_base),
    .out_valid(out_valid), .out_write(out_write), .out_mem(out_mem),
    .out_dev(out_dev), .out_addr(out_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench model of both maps, index 0 = read, 1 = write.
  logic       m_dev  [2][32];
  logic [8:0] m_base [2][32];

  logic        pend = 1'b0;
  logic [23:0] pend_exp = '0;
  string       pend_tag = "R1";

  function automatic logic [23:0] model_out(logic wr, logic [15:0] a);
    logic [4:0] ix;
    ix = a[15:11];
    if (a < 16'h0200)      return {1'b1, wr, 1'b1, 1'b0, 9'd0, a[10:0]};
    else if (m_dev[wr][ix]) return {1'b1, wr, 1'b0, 1'b1, 4'd0, a};
    else                   return {1'b1, wr, 1'b1, 1'b0, m_base[wr][ix], a[10:0]};
  endfunction

  task automatic check_now();
    logic [23:0] act, exp;
    act = {out_valid, out_write, out_mem, out_dev, out_addr};
    exp = pend ? pend_exp : 24'd0;
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got v%0b w%0b m%0b d%0b addr %05h, expected v%0b w%0b m%0b d%0b addr %05h",
               pend_tag, act[23], act[22], act[21], act[20], act[19:0],
               exp[23], exp[22], exp[21], exp[20], exp[19:0]);
    end
  endtask

  // One clock: check the result of the previous step, then drive the next.
  task automatic step(input logic v, input logic wr, input logic [15:0] a,
                      input logic cw, input logic cs, input logic [4:0] ci,
                      input logic cd, input logic [8:0] cb, input string tag);
    @(negedge clk);
    check_now();
    req_valid = v; req_write = wr; req_addr = a;
    cfg_we = cw; cfg_sel = cs; cfg_idx = ci; cfg_dev = cd; cfg_base = cb;
    pend = v;
    pend_tag = tag;
    if (v) pend_exp = model_out(wr, a);
    if (cw) begin
      m_dev[cs][ci]  = cd;
      m_base[cs][ci] = cb;
    end
  endtask

  task automatic acc(input logic wr, input logic [15:0] a, input string tag);
    step(1'b1, wr, a, 1'b0, 1'b0, 5'd0, 1'b0, 9'd0, tag);
  endtask

  task automatic cfg(input logic cs, input logic [4:0] ci, input logic cd,
                     input logic [8:0] cb, input string tag);
    step(1'b0, 1'b0, 16'd0, 1'b1, cs, ci, cd, cb, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 32; i++) begin
        m_dev[t][i]  = (i >= 4);   // R1 reset contents
        m_base[t][i] = 9'd0;
      end
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    pend_tag = "R1";
    check_now();                    // R1: outputs idle after reset

    // R1: every entry of both maps holds its reset value
    for (int i = 0; i < 32; i++) begin
      acc(1'b0, 16'(i * 16'h0800 + 16'h0345), "R1");
      acc(1'b1, 16'(i * 16'h0800 + 16'h0345), "R1");
    end
    // R9: mirrored internal RAM images
    acc(1'b0, 16'h0A05, "R9");
    acc(1'b0, 16'h1A05, "R9");
    // R5: device page passes raw address
    acc(1'b0, 16'hFFFF, "R5");
    // R7: fast path beats a device entry at index 0, boundary at 0x0200
    cfg(1'b0, 5'd0, 1'b1, 9'h005, "R8");
    acc(1'b0, 16'h0000, "R7");
    acc(1'b0, 16'h01FF, "R7");
    acc(1'b0, 16'h0200, "R7");
    acc(1'b1, 16'h0123, "R7");
    // R8: update in the same clock as a lookup, visible one clock later
    step(1'b1, 1'b0, 16'h2000, 1'b1, 1'b0, 5'd4, 1'b0, 9'h1AB, "R8");
    acc(1'b0, 16'h2010, "R8");
    // R6: write map differs from read map on the same page
    cfg(1'b1, 5'd4, 1'b0, 9'h0F0, "R6");
    acc(1'b0, 16'h2222, "R6");
    acc(1'b1, 16'h2222, "R6");
    acc(1'b1, 16'h2800, "R6");
    // R4: top entry direct, all-ones base
    cfg(1'b0, 5'd31, 1'b0, 9'h1FF, "R4");
    acc(1'b0, 16'hFFFF, "R4");
    acc(1'b1, 16'hFFFF, "R4");
    // R2: back-to-back alternating directions, then idle
    for (int i = 0; i < 8; i++) acc(1'(i), 16'(16'h4000 + i * 16'h0111), "R2");
    step(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 5'd0, 1'b0, 9'd0, "R3");
    // Random mix: R3/R4/R5/R6/R8 against the model
    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom % 10);
      step(r < 7, 1'($urandom), 16'($urandom), r >= 5, 1'($urandom),
           5'($urandom), 1'($urandom), 9'($urandom), "R3 R4 R5 R6 R8");
    end
    step(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 5'd0, 1'b0, 9'd0, "R3");
    @(negedge clk);
    check_now();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule